// File: doc/BRIEF.md
# Splittable Compare-Match Timer

This block is an up-counting timer that either runs as one 16-bit counter or is divided into two independent 8-bit counters (a low half and a high half). A mode bit selects the arrangement. Each counter advances only on a one-cycle count-enable. That enable comes from one of four prescaler tap enables, which are block inputs, or from a chosen edge of an external event input. Each half has its own source select.

Each counter is compared with its own compare value on every count-enable. If the counter already equals the compare value when an enable arrives, the half's match flag is set. The counter then either returns to zero or keeps counting. If the half's interrupt enable is set, the match also flips that half's output pin. Wrapping past the all-ones value sets an overflow flag. The single interrupt output is the OR of every flag whose enables are set. Software uses a small synchronous register port to set the configuration, preset the counters, load the compare values, force the pin levels and clear flags.

Top module: `splitcmp_timer`

Register map (3-bit address, 8-bit data, reads are combinational):
- 0 CTRL: bit7 split mode, bits6:4 high-half source, bit3 high-pin level, bits2:0 low-half source.
- 1 CFG: bit7 low-pin level, bit6 edge (1 rising, 0 falling), bit5 high interrupt enable, bit4 low interrupt enable, bit3 high overflow-interrupt enable, bit2 low overflow-interrupt enable, bit1 high clear-on-match, bit0 low clear-on-match.
- 2 STAT: bit3 high overflow, bit2 low overflow, bit1 high match, bit0 low match.
- 3 count low byte, 4 count high byte, 5 compare low byte, 6 compare high byte. Address 7 reads 0.

## Requirements
- R1: After reset, both count bytes read 0x00, both compare bytes read 0xFF, CTRL, CFG and STAT read 0x00, and both output pins and the interrupt output are low.
- R2: With CTRL bit7 at 0, the two bytes form one 16-bit counter in which the high byte advances when the low byte wraps. Match and overflow then use the high-half flags (STAT bits 1 and 3), the high-half enables and the high pin. The low-half flags are never set.
- R3: A source field value of 1, 2, 3 or 4 selects prescaler tap 0, 1, 2 or 3, and 5 selects the external event. Values 0, 6 and 7 stop the counter. In 16-bit mode only the low-half field (CTRL bits2:0) applies.
- R4: With CFG bit6 at 1 the external input counts on its 0-to-1 transitions, and with CFG bit6 at 0 it counts on its 1-to-0 transitions. One transition gives one count.
- R5: A count-enable that arrives while a counter equals its compare value sets that half's match flag.
- R6: A match flips the half's output pin only when that half's interrupt enable is 1. Otherwise the pin keeps its level.
- R7: On a match with the half's clear-on-match bit at 1, the counter goes to 0. With the bit at 0, the counter advances by one as on any other count-enable.
- R8: A write of CTRL loads the high pin from bit3, and a write of CFG loads the low pin from bit7. Such a write decides the pin level even when a toggle happens in the same cycle.
- R9: A count-enable at the all-ones value (0xFF per half, 0xFFFF in 16-bit mode) wraps to zero and sets the overflow flag. That flag drives the interrupt only when both the overflow-interrupt enable and the half's interrupt enable are 1.
- R10: Status flags stay set until software writes STAT. A 0 in a flag's bit clears it, and a 1 leaves it unchanged. A hardware set in the same cycle as a clear leaves the flag set.
- R11: The interrupt output is high exactly while at least one set flag has its enables at 1, and it stays high until such flags are cleared or their enables are removed.
- R12: Writes to the count and compare bytes load them directly. A count write takes precedence over a count-enable in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_en | input | 4 | Prescaler tap count-enables, one cycle each |
| ext_in | input | 1 | External event level, synchronous to clk |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| tmo_hi | output | 1 | High-half (or 16-bit) compare output pin |
| tmo_lo | output | 1 | Low-half compare output pin |
| irq | output | 1 | Interrupt request |

## Verification
A register write, a count-enable or an external edge seen at one rising edge changes the counters, flags and pins at that same edge. The interrupt follows the flags in the same cycle, with no further register. Reads are combinational. Each stimulus is driven at a falling edge and held through exactly one rising edge. The bench then reads back or samples the pins at the next falling edge, so every expected value describes the state one clock after the stimulus. The tick sweeps keep a per-tick arithmetic model of count, pin and flag. This lets every count-enable be checked on its own cycle, including those that land on a match or a wrap.

// File: rtl/splitcmp_pkg.sv
package splitcmp_pkg;

    localparam int HALF_W = 8;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int N_TAPS = 4;
    localparam int SEL_W  = 3;

    typedef logic [HALF_W-1:0] half_t;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0,
        A_CFG  = 3'd1,
        A_STAT = 3'd2,
        A_CNTL = 3'd3,
        A_CNTH = 3'd4,
        A_CMPL = 3'd5,
        A_CMPH = 3'd6,
        A_NONE = 3'd7
    } addr_e;

    typedef struct packed {
        logic             split;
        logic [SEL_W-1:0] sel_hi;
        logic             lvl_hi;
        logic [SEL_W-1:0] sel_lo;
    } ctrl_t;

    typedef struct packed {
        logic lvl_lo;
        logic rise;
        logic ie_hi;
        logic ie_lo;
        logic ovie_hi;
        logic ovie_lo;
        logic clr_hi;
        logic clr_lo;
    } cfg_t;

    typedef struct packed {
        logic ovf_hi;
        logic ovf_lo;
        logic cmf_hi;
        logic cmf_lo;
    } flags_t;

    typedef struct packed {
        logic match_hi;
        logic match_lo;
        logic ovf_hi;
        logic ovf_lo;
    } evt_t;

    localparam int FLAG_W = $bits(flags_t);

    // Source code that selects the external event: one past the last tap.
    function automatic logic [SEL_W-1:0] ext_code();
        return SEL_W'(N_TAPS + 1);
    endfunction

endpackage

// File: rtl/sct_edge_det.sv
module sct_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic ext_in,
    input  logic rise_sel,
    output logic pulse
);
    logic ext_q;

    always_ff @(posedge clk) begin
        if (rst) ext_q <= 1'b0;
        else     ext_q <= ext_in;
    end

    always_comb begin
        if (rise_sel) pulse = ext_in & ~ext_q;
        else          pulse = ~ext_in & ext_q;
    end
endmodule

// File: rtl/sct_tick_sel.sv
module sct_tick_sel
    import splitcmp_pkg::*;
#(
    parameter int TAPS = N_TAPS
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [TAPS-1:0]  taps,
    input  logic             ext_pulse,
    output logic             tick
);
    always_comb begin
        tick = 1'b0;
        for (int k = 0; k < TAPS; k++) begin
            if (sel == SEL_W'(k + 1)) tick = taps[k];
        end
        if (sel == SEL_W'(TAPS + 1)) tick = ext_pulse;
    end
endmodule

// File: rtl/sct_core.sv
module sct_core
    import splitcmp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  split,
    input  logic  tick_lo,
    input  logic  tick_hi,
    input  logic  clr_lo,
    input  logic  clr_hi,
    input  half_t cmp_lo,
    input  half_t cmp_hi,
    input  logic  ld_lo,
    input  logic  ld_hi,
    input  half_t ld_val,
    output half_t cnt_lo,
    output half_t cnt_hi,
    output evt_t  evt
);
    localparam int CNT_W = 2 * HALF_W;
    typedef logic [CNT_W-1:0] wide_t;

    half_t lo_q, hi_q, lo_n, hi_n;
    wide_t wide_cur, wide_cmp, wide_n;

    always_comb begin
        wide_cur = {hi_q, lo_q};
        wide_cmp = {cmp_hi, cmp_lo};
        wide_n   = wide_cur;
        evt      = '0;
        lo_n     = lo_q;
        hi_n     = hi_q;
        if (split) begin
            evt.match_lo = tick_lo && (lo_q == cmp_lo);
            evt.match_hi = tick_hi && (hi_q == cmp_hi);
            if (tick_lo) begin
                if (evt.match_lo && clr_lo) begin
                    lo_n = '0;
                end else begin
                    lo_n       = lo_q + half_t'(1);
                    evt.ovf_lo = (lo_q == '1);
                end
            end
            if (tick_hi) begin
                if (evt.match_hi && clr_hi) begin
                    hi_n = '0;
                end else begin
                    hi_n       = hi_q + half_t'(1);
                    evt.ovf_hi = (hi_q == '1);
                end
            end
        end else begin
            evt.match_hi = tick_lo && (wide_cur == wide_cmp);
            if (tick_lo) begin
                if (evt.match_hi && clr_hi) begin
                    wide_n = '0;
                end else begin
                    wide_n     = wide_cur + wide_t'(1);
                    evt.ovf_hi = (wide_cur == '1);
                end
            end
            {hi_n, lo_n} = wide_n;
        end
        if (ld_lo) lo_n = ld_val;
        if (ld_hi) hi_n = ld_val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    assign cnt_lo = lo_q;
    assign cnt_hi = hi_q;
endmodule

// File: rtl/splitcmp_timer.sv
module splitcmp_timer
    import splitcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [N_TAPS-1:0] tap_en,
    input  logic              ext_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              tmo_hi,
    output logic              tmo_lo,
    output logic              irq
);
    localparam int N_HALF = 2;

    ctrl_t  ctrl_q;
    cfg_t   cfg_q;
    flags_t flg_q, hw_set, wmask;
    half_t  cmp_lo_q, cmp_hi_q, cnt_lo, cnt_hi;
    logic   pin_hi_q, pin_lo_q;
    evt_t   evt;
    addr_e  a;
    logic   we_ctrl, we_cfg, we_stat, ld_lo, ld_hi;
    logic   ext_pulse;
    logic [N_HALF-1:0][SEL_W-1:0] sel_arr;
    logic [N_HALF-1:0]            tick_v;

    assign a       = addr_e'(reg_addr);
    assign we_ctrl = reg_we && (a == A_CTRL);
    assign we_cfg  = reg_we && (a == A_CFG);
    assign we_stat = reg_we && (a == A_STAT);
    assign ld_lo   = reg_we && (a == A_CNTL);
    assign ld_hi   = reg_we && (a == A_CNTH);

    sct_edge_det u_edge (
        .clk     (clk),
        .rst     (rst),
        .ext_in  (ext_in),
        .rise_sel(cfg_q.rise),
        .pulse   (ext_pulse)
    );

    assign sel_arr[0] = ctrl_q.sel_lo;
    assign sel_arr[1] = ctrl_q.sel_hi;

    for (genvar h = 0; h < N_HALF; h++) begin : g_src
        sct_tick_sel #(.TAPS(N_TAPS)) u_sel (
            .sel      (sel_arr[h]),
            .taps     (tap_en),
            .ext_pulse(ext_pulse),
            .tick     (tick_v[h])
        );
    end

    sct_core u_core (
        .clk    (clk),
        .rst    (rst),
        .split  (ctrl_q.split),
        .tick_lo(tick_v[0]),
        .tick_hi(tick_v[1]),
        .clr_lo (cfg_q.clr_lo),
        .clr_hi (cfg_q.clr_hi),
        .cmp_lo (cmp_lo_q),
        .cmp_hi (cmp_hi_q),
        .ld_lo  (ld_lo),
        .ld_hi  (ld_hi),
        .ld_val (reg_wdata),
        .cnt_lo (cnt_lo),
        .cnt_hi (cnt_hi),
        .evt    (evt)
    );

    // Configuration and compare registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            cfg_q    <= '0;
            cmp_lo_q <= '1;
            cmp_hi_q <= '1;
        end else if (reg_we) begin
            case (a)
                A_CTRL: ctrl_q   <= ctrl_t'(reg_wdata);
                A_CFG:  cfg_q    <= cfg_t'(reg_wdata);
                A_CMPL: cmp_lo_q <= reg_wdata;
                A_CMPH: cmp_hi_q <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Sticky flags: hardware set dominates a software clear
    assign hw_set = '{ovf_hi: evt.ovf_hi, ovf_lo: evt.ovf_lo,
                      cmf_hi: evt.match_hi, cmf_lo: evt.match_lo};
    assign wmask  = flags_t'(reg_wdata[FLAG_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) flg_q <= '0;
        else     flg_q <= hw_set | (we_stat ? (flg_q & wmask) : flg_q);
    end

    // Output pins: a level write dominates a match toggle
    always_ff @(posedge clk) begin
        if (rst) begin
            pin_hi_q <= 1'b0;
            pin_lo_q <= 1'b0;
        end else begin
            if (we_ctrl)                         pin_hi_q <= reg_wdata[3];
            else if (evt.match_hi && cfg_q.ie_hi) pin_hi_q <= ~pin_hi_q;
            if (we_cfg)                          pin_lo_q <= reg_wdata[7];
            else if (evt.match_lo && cfg_q.ie_lo) pin_lo_q <= ~pin_lo_q;
        end
    end

    assign tmo_hi = pin_hi_q;
    assign tmo_lo = pin_lo_q;

    assign irq = (flg_q.cmf_lo & cfg_q.ie_lo)
               | (flg_q.cmf_hi & cfg_q.ie_hi)
               | (flg_q.ovf_lo & cfg_q.ovie_lo & cfg_q.ie_lo)
               | (flg_q.ovf_hi & cfg_q.ovie_hi & cfg_q.ie_hi);

    always_comb begin
        case (a)
            A_CTRL:  reg_rdata = ctrl_q;
            A_CFG:   reg_rdata = cfg_q;
            A_STAT:  reg_rdata = DATA_W'(flg_q);
            A_CNTL:  reg_rdata = cnt_lo;
            A_CNTH:  reg_rdata = cnt_hi;
            A_CMPL:  reg_rdata = cmp_lo_q;
            A_CMPH:  reg_rdata = cmp_hi_q;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sct_checker.sv
module sct_checker
    import splitcmp_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   split,
    input logic   tick_lo,
    input logic   ld_lo,
    input logic   ld_hi,
    input logic   we_ctrl,
    input logic   we_cfg,
    input logic   we_stat,
    input logic   ie_hi,
    input logic   clr_hi,
    input half_t  cnt_lo,
    input half_t  cnt_hi,
    input evt_t   evt,
    input flags_t flg,
    input logic   tmo_hi,
    input logic   tmo_lo,
    input logic   irq
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!tmo_hi && !tmo_lo && !irq));

    p_wide_lo_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !split |-> !(evt.match_lo || evt.ovf_lo));

    p_lo_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick_lo && !ld_lo) |=> $stable(cnt_lo));

    p_toggle_gated_r6: assert property (@(posedge clk) disable iff (rst)
        (!ie_hi && !we_ctrl) |=> $stable(tmo_hi));

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (!split && evt.match_hi && clr_hi && !ld_lo && !ld_hi)
        |=> (cnt_lo == '0 && cnt_hi == '0));

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (flg.cmf_hi && !we_stat) |=> flg.cmf_hi);

    p_irq_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (irq && !we_stat && !we_cfg) |=> irq);
endmodule

bind splitcmp_timer sct_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .split  (ctrl_q.split),
    .tick_lo(tick_v[0]),
    .ld_lo  (ld_lo),
    .ld_hi  (ld_hi),
    .we_ctrl(we_ctrl),
    .we_cfg (we_cfg),
    .we_stat(we_stat),
    .ie_hi  (cfg_q.ie_hi),
    .clr_hi (cfg_q.clr_hi),
    .cnt_lo (cnt_lo),
    .cnt_hi (cnt_hi),
    .evt    (evt),
    .flg    (flg_q),
    .tmo_hi (tmo_hi),
    .tmo_lo (tmo_lo),
    .irq    (irq)
);

// File: tb/splitcmp_timer_tb.sv
module splitcmp_timer_tb;
    import splitcmp_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  tap_en = '0;
    logic        ext_in = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        tmo_hi, tmo_lo, irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    splitcmp_timer u_dut (
        .clk(clk), .rst(rst), .tap_en(tap_en), .ext_in(ext_in),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tmo_hi(tmo_hi), .tmo_lo(tmo_lo), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic tick(input int k);
        @(negedge clk);
        tap_en = 4'(1 << k);
        @(negedge clk);
        tap_en = '0;
    endtask

    // register write and tap pulse in the same cycle
    task automatic wr_tick(input logic [2:0] a, input logic [7:0] d, input int k);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; tap_en = 4'(1 << k);
        @(negedge clk);
        reg_we = 1'b0; tap_en = '0;
    endtask

    task automatic ext_step(input logic v);
        @(negedge clk);
        ext_in = v;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int m_cnt, m_pin, m_flag;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(A_CTRL, d); chk("R1 ctrl", d, 8'h00);
        rd(A_CFG,  d); chk("R1 cfg",  d, 8'h00);
        rd(A_STAT, d); chk("R1 stat", d, 8'h00);
        rd(A_CNTL, d); chk("R1 cntl", d, 8'h00);
        rd(A_CNTH, d); chk("R1 cnth", d, 8'h00);
        rd(A_CMPL, d); chk("R1 cmpl", d, 8'hFF);
        rd(A_CMPH, d); chk("R1 cmph", d, 8'hFF);
        chk("R1 pins+irq", {tmo_hi, tmo_lo, irq}, 0);
        tick(0);
        rd(A_CNTL, d); chk("R3 source 0 stops", d, 8'h00);

        // R5 R6 R7 sweep of low half in split mode
        for (int clr = 0; clr < 2; clr++) begin
            for (int ci = 0; ci < 2; ci++) begin
                int cmpv;
                cmpv = (ci == 0) ? 3 : 7;
                wr(A_CTRL, 8'h81);
                wr(A_CFG, 8'h10 | 8'(clr));
                wr(A_CMPL, 8'(cmpv));
                wr(A_CNTL, 8'h00);
                wr(A_STAT, 8'h00);
                m_cnt = 0; m_pin = 0; m_flag = 0;
                for (int t = 0; t < 20; t++) begin
                    tick(0);
                    if (m_cnt == cmpv) begin
                        m_flag = 1;
                        m_pin  = m_pin ^ 1;
                        m_cnt  = clr ? 0 : ((m_cnt + 1) & 8'hFF);
                    end else begin
                        m_cnt = (m_cnt + 1) & 8'hFF;
                    end
                    rd(A_CNTL, d); chk("R7 count after tick", d, m_cnt);
                    chk("R6 low pin", tmo_lo, m_pin);
                end
                rd(A_STAT, d); chk("R5 low match flag", d[0], m_flag);
                rd(A_CNTH, d); chk("R3 high half untouched", d, 0);
            end
        end

        // R3 R6 R5 high half on tap 2, interrupt enable off
        wr(A_CTRL, 8'hB0);
        wr(A_CFG, 8'h02);
        wr(A_CMPH, 8'h02);
        wr(A_CNTH, 8'h00);
        wr(A_CNTL, 8'h00);
        wr(A_STAT, 8'h00);
        m_cnt = 0;
        for (int t = 0; t < 6; t++) begin
            tick(2);
            m_cnt = (m_cnt == 2) ? 0 : m_cnt + 1;
            rd(A_CNTH, d); chk("R3 tap2 drives high half", d, m_cnt);
            chk("R6 no toggle without enable", tmo_hi, 0);
        end
        tick(0);
        rd(A_CNTL, d); chk("R3 low source off", d, 0);
        rd(A_STAT, d); chk("R5 high match flag", d, 8'h02);

        // R3 codes 6 and 7 stop
        for (int s = 6; s < 8; s++) begin
            wr(A_CTRL, 8'h80 | 8'(s));
            @(negedge clk); tap_en = 4'hF; @(negedge clk); tap_en = '0;
            rd(A_CNTL, d); chk("R3 unused codes stop", d, 0);
        end

        // R9 R10 R11 low overflow
        wr(A_CTRL, 8'h81);
        wr(A_CFG, 8'h10);
        wr(A_CMPL, 8'h10);
        wr(A_CNTL, 8'hFE);
        wr(A_STAT, 8'h00);
        tick(0); tick(0);
        rd(A_CNTL, d); chk("R9 wrap to zero", d, 0);
        rd(A_STAT, d); chk("R9 overflow flag", d, 8'h04);
        chk("R9 no irq without overflow enable", irq, 0);
        wr(A_CFG, 8'h14);
        chk("R11 irq from enabled flag", irq, 1);
        wr(A_STAT, 8'hFF);
        rd(A_STAT, d); chk("R10 write one keeps", d, 8'h04);
        chk("R11 irq held", irq, 1);
        wr(A_STAT, 8'h00);
        rd(A_STAT, d); chk("R10 write zero clears", d, 8'h00);
        chk("R11 irq drops", irq, 0);

        // R2 R7 16-bit mode
        wr(A_CTRL, 8'h01);
        wr(A_CFG, 8'h22);
        wr(A_CMPL, 8'h02);
        wr(A_CMPH, 8'h01);
        wr(A_CNTL, 8'hFF);
        wr(A_CNTH, 8'h00);
        tick(0);
        rd(A_CNTL, d); chk("R2 low byte wraps", d, 8'h00);
        rd(A_CNTH, d); chk("R2 carry into high byte", d, 8'h01);
        tick(0); tick(0);
        rd(A_CNTL, d); chk("R5 reaches compare", d, 8'h02);
        chk("R5 no toggle before match tick", tmo_hi, 0);
        tick(0);
        rd(A_CNTL, d); chk("R7 wide clear low", d, 0);
        rd(A_CNTH, d); chk("R7 wide clear high", d, 0);
        chk("R6 wide toggle", tmo_hi, 1);
        rd(A_STAT, d); chk("R2 only high match flag", d, 8'h02);
        chk("R11 wide irq", irq, 1);
        wr(A_CFG, 8'h28);
        wr(A_CMPL, 8'h34);
        wr(A_CMPH, 8'h12);
        wr(A_STAT, 8'h00);
        wr(A_CNTL, 8'hFF);
        wr(A_CNTH, 8'hFF);
        tick(0);
        rd(A_CNTH, d); chk("R9 16-bit wrap", d, 0);
        rd(A_STAT, d); chk("R9 16-bit overflow flag", d, 8'h08);
        chk("R9 16-bit overflow irq", irq, 1);
        chk("R6 overflow does not toggle", tmo_hi, 1);

        // R4 external edges
        wr(A_CTRL, 8'h85);
        for (int r = 1; r >= 0; r--) begin
            wr(A_CFG, 8'(r << 6));
            wr(A_CNTL, 8'h00);
            m_cnt = 0;
            for (int s = 0; s < 8; s++) begin
                ext_step(~ext_in);
                if ((r == 1 && ext_in == 1'b1) || (r == 0 && ext_in == 1'b0)) m_cnt++;
                rd(A_CNTL, d); chk("R4 edge count", d, m_cnt);
            end
        end

        // R8 level write beats toggle; R10 hardware set beats clear
        wr(A_CTRL, 8'h81);
        wr(A_CFG, 8'h10);
        wr(A_CMPL, 8'h05);
        wr(A_CNTL, 8'h05);
        wr(A_STAT, 8'h00);
        wr_tick(A_CFG, 8'h10, 0);
        chk("R8 write wins over toggle", tmo_lo, 0);
        rd(A_STAT, d); chk("R5 match in write cycle", d[0], 1);
        wr(A_CNTL, 8'h05);
        wr_tick(A_STAT, 8'h00, 0);
        rd(A_STAT, d); chk("R10 set beats clear", d[0], 1);
        wr(A_CFG, 8'h90);
        chk("R8 low level forced", tmo_lo, 1);
        wr(A_CTRL, 8'h89);
        chk("R8 high level forced", tmo_hi, 1);
        wr(A_CTRL, 8'h81);
        chk("R8 high level cleared", tmo_hi, 0);

        // R12 loads
        wr_tick(A_CNTL, 8'h40, 0);
        rd(A_CNTL, d); chk("R12 load beats tick", d, 8'h40);
        wr(A_CMPH, 8'h5A);
        rd(A_CMPH, d); chk("R12 compare load", d, 8'h5A);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule